// File: doc/BRIEF.md
# Sprite Page DMA Engine

This block fills sprite attribute memory from main memory when the processor hands it a page number. A write of one byte to the trigger register index records that byte in a shadow register. The top three bits of the byte select the source region. When the region holds memory, the engine then reads the 256 bytes of that page and writes each one into sprite memory. The writes start at sprite address zero and go up in order.

Each region masks the source offset in its own way. Work RAM is a 2 KB window that repeats, so only the low 11 offset bits survive. The SRAM window and the four ROM banks are 8 KB each and keep 13 bits. The two regions that hold video and sound/I/O registers are not memory, so selecting one of them starts no copy. The engine reads through a simple master port: an address and a strobe go out, and the data comes back in the cycle after the strobe. The `busy` output tells the processor side that a copy is running.

Top module: `spr_page_dma`

## Requirements
- R1: After reset, `busy`, `mem_rd_stb` and `spr_wr_en` are low and `shadow_q` is 0x00.
- R2: While idle, a write with `reg_idx` = 0x14 puts `reg_wr_data` on `shadow_q` from the next cycle on. A write to any other index changes neither `shadow_q` nor `busy`.
- R3: A trigger whose page bits 7:5 are 000, 011 or 1xx starts a copy. `busy` is high in the first cycle after the trigger write. `mem_rd_stb` is then high for 256 consecutive cycles, and the offsets run from 0 to 255 in ascending order.
- R4: For offset i, the source address is {page[7:5], ((page<<8 | i)[12:0] & mask)}. The mask is 0x07FF when page[7:5] = 000 and 0x1FFF otherwise.
- R5: Each byte read is written in the cycle after its strobe, with `spr_wr_data` equal to that cycle's `mem_rd_data`. The writes go to `spr_wr_addr` 0 to 255 in order, exactly once each.
- R6: A trigger whose page bits 7:5 are 001 or 010 updates `shadow_q`. It issues no strobe and no sprite write, and `busy` stays low.
- R7: A copy holds `busy` high for exactly 257 cycles. `busy` falls in the cycle after the last sprite write.
- R8: A trigger write while `busy` is high is ignored. `shadow_q` keeps its value and the running copy goes on with its original page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register index of the write |
| reg_wr_data | input | 8 | Register write data (page number) |
| shadow_q | output | 8 | Last accepted trigger value |
| mem_rd_stb | output | 1 | Source read strobe |
| mem_rd_addr | output | 16 | Source read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| spr_wr_en | output | 1 | Sprite memory write enable |
| spr_wr_addr | output | 8 | Sprite memory write address |
| spr_wr_data | output | 8 | Sprite memory write data |
| busy | output | 1 | Copy in progress |

## Verification
Two events can land in the same cycle: a new trigger write and the final sprite write of a running copy, while `busy` is still high. The bench provokes this by driving a trigger in the 257th busy cycle. It then drives another trigger in the very next cycle, once `busy` has dropped. The first trigger must leave `shadow_q` and the address stream untouched. The second must start a fresh, complete copy. A behavioural memory returns a data value derived from the address, and every strobe and write is compared against values computed from the page for all eight region codes.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

   // Source region code taken from page bits 7:5
   typedef enum logic [2:0] {
      SRC_WRAM  = 3'd0,
      SRC_VIDEO = 3'd1,
      SRC_IOREG = 3'd2,
      SRC_SRAM  = 3'd3,
      SRC_ROM0  = 3'd4,
      SRC_ROM1  = 3'd5,
      SRC_ROM2  = 3'd6,
      SRC_ROM3  = 3'd7
   } src_region_e;

   // Regions backed by memory are copied; register windows are not
   function automatic logic region_copies(input logic [2:0] code);
      return !(code == SRC_VIDEO || code == SRC_IOREG);
   endfunction

   // Region zero is the mirrored work RAM; all others use the bank mask
   function automatic logic region_is_mirror(input logic [2:0] code);
      return code == SRC_WRAM;
   endfunction

endpackage

// File: rtl/spr_dma_src_map.sv
module spr_dma_src_map
   import spr_dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SEL_W = 3,
   parameter logic [ADDR_W-SEL_W-1:0] MIRROR_MASK = 'h07FF,
   parameter logic [ADDR_W-SEL_W-1:0] BANK_MASK = 'h1FFF
) (
   input  logic [ADDR_W-1:0] linear_addr,
   output logic              copy_ok,
   output logic [ADDR_W-1:0] src_addr
);
   localparam int OFF_W = ADDR_W - SEL_W;
   localparam int N_REG = 1 << SEL_W;

   logic [OFF_W-1:0] mask_tbl [N_REG];
   logic [N_REG-1:0] copy_tbl;
   logic [SEL_W-1:0] sel;
   logic [OFF_W-1:0] offset;

   initial begin
      assert (SEL_W == 3) else $error("region decode expects three select bits");
      assert (OFF_W > 0) else $error("address too narrow for region select");
   end

   // Per-region mask and copy table, built once per region
   for (genvar g = 0; g < N_REG; g++) begin : g_region
      assign mask_tbl[g] = region_is_mirror(3'(g)) ? MIRROR_MASK : BANK_MASK;
      assign copy_tbl[g] = region_copies(3'(g));
   end

   assign sel      = linear_addr[ADDR_W-1 -: SEL_W];
   assign offset   = linear_addr[OFF_W-1:0] & mask_tbl[sel];
   assign copy_ok  = copy_tbl[sel];
   assign src_addr = {sel, offset};

endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq #(
   parameter int CNT_W = 8,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PAGE_W-1:0] start_page,
   output logic              rd_act,
   output logic [CNT_W-1:0]  idx,
   output logic [PAGE_W-1:0] page
);
   localparam logic [CNT_W-1:0] LAST_IDX = {CNT_W{1'b1}};

   logic              act_q;
   logic [CNT_W-1:0]  idx_q;
   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         idx_q  <= '0;
         page_q <= '0;
      end else if (start) begin
         act_q  <= 1'b1;
         idx_q  <= '0;
         page_q <= start_page;
      end else if (act_q) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST_IDX) act_q <= 1'b0;
      end
   end

   assign rd_act = act_q;
   assign idx    = idx_q;
   assign page   = page_q;

   // R3: reads advance one offset per cycle
   p_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_q && $past(act_q) |-> idx_q == CNT_W'($past(idx_q) + 1'b1));

   // R3: a copy begins at offset zero
   p_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> idx_q == '0);

   // R8: the page is frozen while reads run
   p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      act_q && $past(act_q) |-> $stable(page_q));

endmodule

// File: rtl/spr_dma_wr_stage.sv
module spr_dma_wr_stage #(
   parameter int CNT_W = 8,
   parameter int DATA_W = 8,
   parameter bit WR_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic [CNT_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_data,
   output logic              spr_wr_en,
   output logic [CNT_W-1:0]  spr_wr_addr,
   output logic [DATA_W-1:0] spr_wr_data,
   output logic              pend
);
   logic             v1_q;
   logic [CNT_W-1:0] a1_q;

   // Stage 1: remember which offset the returning data belongs to
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         a1_q <= '0;
      end else begin
         v1_q <= rd_fire;
         a1_q <= rd_idx;
      end
   end

   if (WR_REG) begin : g_reg
      logic              v2_q;
      logic [CNT_W-1:0]  a2_q;
      logic [DATA_W-1:0] d2_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v2_q <= 1'b0;
            a2_q <= '0;
            d2_q <= '0;
         end else begin
            v2_q <= v1_q;
            a2_q <= a1_q;
            d2_q <= rd_data;
         end
      end

      assign spr_wr_en   = v2_q;
      assign spr_wr_addr = a2_q;
      assign spr_wr_data = d2_q;
      assign pend        = v1_q | v2_q;
   end else begin : g_pass
      assign spr_wr_en   = v1_q;
      assign spr_wr_addr = a1_q;
      assign spr_wr_data = rd_data;
      assign pend        = v1_q;

      // R5: each read is written in the following cycle at its own offset
      p_wr_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rd_fire) |-> spr_wr_en && spr_wr_addr == $past(rd_idx));
   end

endmodule

// File: rtl/spr_page_dma.sv
module spr_page_dma
   import spr_dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int PAGE_BYTES = 256,
   parameter int REG_W = 5,
   parameter logic [REG_W-1:0] TRIG_IDX = 5'h14,
   parameter int SEL_W = 3,
   parameter logic [ADDR_W-SEL_W-1:0] MIRROR_MASK = 'h07FF,
   parameter logic [ADDR_W-SEL_W-1:0] BANK_MASK = 'h1FFF,
   parameter bit WR_REG = 1'b0,
   localparam int CNT_W = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wr_data,
   output logic [DATA_W-1:0] shadow_q,
   output logic              mem_rd_stb,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              spr_wr_en,
   output logic [CNT_W-1:0]  spr_wr_addr,
   output logic [DATA_W-1:0] spr_wr_data,
   output logic              busy
);
   localparam int PAGE_W = ADDR_W - CNT_W;

   initial begin
      assert (PAGE_BYTES == (1 << CNT_W)) else $error("page size must be a power of two");
      assert (PAGE_W == DATA_W) else $error("page number must fill one data word");
      assert (SEL_W <= PAGE_W) else $error("region select wider than page number");
   end

   logic              trig_hit;
   logic              start;
   logic              trig_copy;
   logic              rd_act;
   logic              wr_pend;
   logic [CNT_W-1:0]  rd_idx;
   logic [PAGE_W-1:0] cur_page;
   logic [DATA_W-1:0] shadow_r;
   logic              run_copy_ok;
   logic [ADDR_W-1:0] trig_src_unused;

   assign busy     = rd_act | wr_pend;
   assign trig_hit = reg_wr_en && (reg_idx == TRIG_IDX) && !busy;

   // Region check for the incoming page number
   spr_dma_src_map #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W),
      .MIRROR_MASK(MIRROR_MASK), .BANK_MASK(BANK_MASK)
   ) u_trig_map (
      .linear_addr({reg_wr_data, {CNT_W{1'b0}}}),
      .copy_ok(trig_copy),
      .src_addr(trig_src_unused)
   );

   assign start = trig_hit && trig_copy;

   always_ff @(posedge clk) begin
      if (!rst_n) shadow_r <= '0;
      else if (trig_hit) shadow_r <= reg_wr_data;
   end
   assign shadow_q = shadow_r;

   spr_dma_seq #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_page(reg_wr_data),
      .rd_act(rd_act), .idx(rd_idx), .page(cur_page)
   );

   // Address mapping for the running copy
   spr_dma_src_map #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W),
      .MIRROR_MASK(MIRROR_MASK), .BANK_MASK(BANK_MASK)
   ) u_run_map (
      .linear_addr({cur_page, rd_idx}),
      .copy_ok(run_copy_ok),
      .src_addr(mem_rd_addr)
   );

   assign mem_rd_stb = rd_act;

   spr_dma_wr_stage #(.CNT_W(CNT_W), .DATA_W(DATA_W), .WR_REG(WR_REG)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .rd_fire(rd_act), .rd_idx(rd_idx), .rd_data(mem_rd_data),
      .spr_wr_en(spr_wr_en), .spr_wr_addr(spr_wr_addr), .spr_wr_data(spr_wr_data),
      .pend(wr_pend)
   );

   // R8: trigger writes during a copy leave the shadow alone
   p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(shadow_q));

   // R6: register-window pages never raise busy
   p_no_io_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit && !trig_copy |=> !busy);

   // R4: mirrored work RAM keeps only eleven offset bits
   p_wram_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_stb && mem_rd_addr[ADDR_W-1 -: SEL_W] == '0 |-> mem_rd_addr[ADDR_W-SEL_W-1:11] == '0);

   // R3: only memory regions ever get read
   p_run_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_stb |-> run_copy_ok);

   // R7: busy drops right after the last sprite write
   p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(spr_wr_en) && $past(spr_wr_addr) == {CNT_W{1'b1}});

endmodule

// File: tb/spr_page_dma_tb.sv
module spr_page_dma_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [4:0] reg_idx = '0;
   logic [7:0] reg_wr_data = '0;
   logic [7:0] shadow_q;
   logic       mem_rd_stb;
   logic [15:0] mem_rd_addr;
   logic [7:0] mem_rd_data = '0;
   logic       spr_wr_en;
   logic [7:0] spr_wr_addr;
   logic [7:0] spr_wr_data;
   logic       busy;

   int total = 0;
   int bad = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   logic [7:0] cur_page = '0;

   always #10 clk = ~clk;

   spr_page_dma u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_idx(reg_idx), .reg_wr_data(reg_wr_data),
      .shadow_q(shadow_q),
      .mem_rd_stb(mem_rd_stb), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .spr_wr_en(spr_wr_en), .spr_wr_addr(spr_wr_addr), .spr_wr_data(spr_wr_data),
      .busy(busy)
   );

   function automatic logic [7:0] mdl(input logic [15:0] a);
      return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [15:0] exp_addr(input logic [7:0] pg, input int i);
      logic [15:0] lin;
      logic [12:0] off;
      lin = {pg, 8'(i)};
      off = lin[12:0] & ((pg[7:5] == 3'b000) ? 13'h07FF : 13'h1FFF);
      return {pg[7:5], off};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Behavioural source memory: data one cycle after the strobe
   always @(posedge clk) if (mem_rd_stb) mem_rd_data <= mdl(mem_rd_addr);

   // Stream monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_stb) begin
            chk(mem_rd_addr == exp_addr(cur_page, rd_cnt), "R4 read address",
                int'(mem_rd_addr), int'(exp_addr(cur_page, rd_cnt)));
            rd_cnt++;
         end
         if (spr_wr_en) begin
            chk(int'(spr_wr_addr) == wr_cnt, "R5 write address", int'(spr_wr_addr), wr_cnt);
            chk(spr_wr_data == mdl(exp_addr(cur_page, wr_cnt)), "R5 write data",
                int'(spr_wr_data), int'(mdl(exp_addr(cur_page, wr_cnt))));
            wr_cnt++;
         end
      end
   end

   task automatic run_page(input logic [7:0] pg, input int inj);
      bit cp;
      int n;
      cp = !(pg[7:5] == 3'b001 || pg[7:5] == 3'b010);
      cur_page = pg;
      rd_cnt = 0;
      wr_cnt = 0;
      reg_wr_en = 1'b1; reg_idx = 5'h14; reg_wr_data = pg;
      @(negedge clk);
      reg_wr_en = 1'b0;
      chk(shadow_q == pg, "R2 shadow", int'(shadow_q), int'(pg));
      chk(busy == cp, cp ? "R3 busy rise" : "R6 busy low", int'(busy), int'(cp));
      n = 0;
      while (busy && n < 400) begin
         if (n == inj) begin
            reg_wr_en = 1'b1; reg_idx = 5'h14; reg_wr_data = ~pg;
         end else begin
            reg_wr_en = 1'b0;
         end
         n++;
         @(negedge clk);
      end
      reg_wr_en = 1'b0;
      chk(n == (cp ? 257 : 0), "R7 busy length", n, cp ? 257 : 0);
      if (inj >= 0) chk(shadow_q == pg, "R8 shadow kept", int'(shadow_q), int'(pg));
      if (!cp) repeat (3) @(negedge clk);
      chk(rd_cnt == (cp ? 256 : 0), cp ? "R3 read count" : "R6 no reads", rd_cnt, cp ? 256 : 0);
      chk(wr_cnt == (cp ? 256 : 0), cp ? "R5 write count" : "R6 no writes", wr_cnt, cp ? 256 : 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy, "R1 busy", int'(busy), 0);
      chk(!mem_rd_stb, "R1 strobe", int'(mem_rd_stb), 0);
      chk(!spr_wr_en, "R1 write", int'(spr_wr_en), 0);
      chk(shadow_q == 8'h00, "R1 shadow", int'(shadow_q), 0);

      // R2: every other register index is ignored
      for (int k = 0; k < 32; k++) begin
         if (k != 'h14) begin
            reg_wr_en = 1'b1; reg_idx = 5'(k); reg_wr_data = 8'h85;
            @(negedge clk);
            reg_wr_en = 1'b0;
            @(negedge clk);
            chk(shadow_q == 8'h00, "R2 other index shadow", int'(shadow_q), 0);
            chk(!busy, "R2 other index busy", int'(busy), 0);
         end
      end

      // R3 R4 R5 R6 R7: all region codes, several low page bits
      for (int s = 0; s < 8; s++) begin
         run_page({3'(s), 5'h00}, -1);
         run_page({3'(s), 5'h1F}, -1);
         run_page({3'(s), 5'h0A}, -1);
      end

      // R8: trigger in the middle of a copy
      run_page(8'h03, 100);
      // R8: trigger in the final busy cycle, then back-to-back accepted trigger
      run_page(8'hC7, 256);
      run_page(8'h65, -1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule